// File: doc/BRIEF.md
# Load Data Aligner and Extender

This unit sits on the load return path of a processor pipeline, between a 32-bit big-endian data memory and register write-back. Each cycle it may accept one aligned memory word, together with the two low address bits of the load, the access size and a flag that selects zero extension. It picks the addressed byte or halfword out of the word and widens it to 32 bits with sign or zero fill. It also checks that the address is a multiple of the access size.

The result is registered. A load strobed in one cycle shows its value and its error flag in the next cycle, paired with an output valid. A load that fails the alignment check raises the error flag and does not write the result register, so the result seen by a trap handler is the last good one. The access size is encoded as 00 = byte, 01 = halfword, 10 = word, and 11 is also handled as a word. `ld_zext` = 1 requests zero extension.

Top module: `ldx_load_aligner`

## Requirements
- R1: For a byte load, address offset k (0..3) selects word bits [31-8k : 24-8k], so offset 0 is the most significant byte.
- R2: For a halfword load, address bit 1 = 0 selects word bits 31:16 and address bit 1 = 1 selects bits 15:0.
- R3: With `ld_zext` = 0, a byte or halfword result copies the top bit of the selected field into every higher bit (byte 0x8C gives 0xFFFFFF8C).
- R4: With `ld_zext` = 1, a byte or halfword result has all bits above the field cleared (byte 0x0A gives 0x0000000A).
- R5: A word load (size 10 or 11) returns the whole memory word unchanged, whatever the value of `ld_zext`.
- R6: Misalignment is detected by size: a byte is never misaligned, a halfword is misaligned when address bit 0 = 1, and a word is misaligned when either address bit is 1.
- R7: A misaligned load drives `res_misalign` = 1 together with `res_valid`, and leaves `res_data` at its previous value.
- R8: `res_valid` equals `ld_valid` delayed by exactly one clock. `res_misalign` is 1 only while `res_valid` is 1, and the result of a strobed load appears in that same cycle.
- R9: A synchronous active-high reset clears `res_valid`, `res_misalign` and `res_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe for this cycle |
| ld_word | input | 32 | Aligned word read from memory |
| ld_addr_lo | input | 2 | Low two bits of the load byte address |
| ld_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| ld_zext | input | 1 | 1 = zero extend, 0 = sign extend |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_data | output | 32 | Aligned and extended register value |
| res_misalign | output | 1 | Misaligned access flag for this result |

## Verification
The assertions check the following on every cycle: the one-clock valid timing, that the error never appears without a valid, that a misaligned strobe leaves the result unchanged, that byte loads never flag an error, and the shape of the upper bits for byte loads under both extension kinds. Only the bench scenarios can show that the correct lane was picked for each offset, that halfword lanes follow big-endian order, and that word loads ignore the extension flag. The same holds for reset in the middle of a run and for the error clearing on the next good load, because these need known data words and expected values.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  localparam int LDX_BYTE_W = 8;
  localparam int LDX_LANES  = 4;
  localparam int LDX_DATA_W = LDX_BYTE_W * LDX_LANES;
  localparam int LDX_OFS_W  = $clog2(LDX_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } ldx_size_e;
endpackage

// File: rtl/ldx_lane_pick.sv
module ldx_lane_pick
  import ldx_pkg::*;
#(
  parameter int BYTE_W = LDX_BYTE_W,
  parameter int LANES  = LDX_LANES,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]   word_i,
  input  logic [OFS_W-1:0]    ofs_i,
  output logic [BYTE_W-1:0]   byte_o,
  output logic [2*BYTE_W-1:0] half_o
);
  // big-endian lane numbering: lane 0 is the most significant byte
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[DATA_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    logic [OFS_W-1:0] hbase;
    byte_o = lane[ofs_i];
    hbase  = {ofs_i[OFS_W-1:1], 1'b0};
    half_o = {lane[hbase], lane[hbase | OFS_W'(1)]};
  end
endmodule

// File: rtl/ldx_extend.sv
module ldx_extend
  import ldx_pkg::*;
#(
  parameter int BYTE_W = LDX_BYTE_W,
  parameter int LANES  = LDX_LANES,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [HALF_W-1:0] half_i,
  input  ldx_size_e         size_i,
  input  logic              zext_i,
  output logic [DATA_W-1:0] data_o
);
  logic byte_fill, half_fill;

  assign byte_fill = ~zext_i & byte_i[BYTE_W-1];
  assign half_fill = ~zext_i & half_i[HALF_W-1];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-BYTE_W){byte_fill}}, byte_i};
      SZ_HALF: data_o = {{(DATA_W-HALF_W){half_fill}}, half_i};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/ldx_align_check.sv
module ldx_align_check
  import ldx_pkg::*;
#(
  parameter int OFS_W = LDX_OFS_W
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  ldx_size_e        size_i,
  output logic             bad_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: bad_o = 1'b0;
      SZ_HALF: bad_o = ofs_i[0];
      default: bad_o = |ofs_i;
    endcase
  end
endmodule

// File: rtl/ldx_load_aligner.sv
module ldx_load_aligner
  import ldx_pkg::*;
#(
  parameter int BYTE_W = LDX_BYTE_W,
  parameter int LANES  = LDX_LANES,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_word,
  input  logic [OFS_W-1:0]  ld_addr_lo,
  input  logic [1:0]        ld_size,
  input  logic              ld_zext,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_misalign
);
  ldx_size_e           size_q;
  logic [BYTE_W-1:0]   sel_byte;
  logic [2*BYTE_W-1:0] sel_half;
  logic [DATA_W-1:0]   ext_data;
  logic                misaligned;

  assign size_q = ldx_size_e'(ld_size);

  ldx_lane_pick #(.BYTE_W(BYTE_W), .LANES(LANES)) pick_i (
    .word_i(ld_word), .ofs_i(ld_addr_lo), .byte_o(sel_byte), .half_o(sel_half)
  );

  ldx_extend #(.BYTE_W(BYTE_W), .LANES(LANES)) ext_i (
    .word_i(ld_word), .byte_i(sel_byte), .half_i(sel_half),
    .size_i(size_q), .zext_i(ld_zext), .data_o(ext_data)
  );

  ldx_align_check #(.OFS_W(OFS_W)) chk_i (
    .ofs_i(ld_addr_lo), .size_i(size_q), .bad_o(misaligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_misalign <= 1'b0;
      res_data     <= '0;
    end else begin
      res_valid    <= ld_valid;
      res_misalign <= ld_valid & misaligned;
      if (ld_valid && !misaligned) res_data <= ext_data;
    end
  end

  // R8: valid follows strobe by one clock
  assert_vld_rise_R8: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> res_valid);
  assert_vld_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> !res_valid);
  // R8: error never without valid
  assert_err_gated_R8: assert property (@(posedge clk) disable iff (rst)
    res_misalign |-> res_valid);
  // R7: misaligned strobe keeps the previous result
  assert_hold_on_err_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && misaligned) |=> (res_misalign && $stable(res_data)));
  // R6: byte access never flags
  assert_byte_ok_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && size_q == SZ_BYTE) |=> !res_misalign);
  // R4: unsigned byte has clear upper bits
  assert_byte_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && size_q == SZ_BYTE && ld_zext) |=> (res_data[DATA_W-1:BYTE_W] == '0));
  // R3: signed byte upper bits copy the field msb
  assert_byte_sext_R3: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && size_q == SZ_BYTE && !ld_zext) |=>
      (res_data[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){res_data[BYTE_W-1]}}));
endmodule

// File: tb/ldx_load_aligner_tb_top.sv
module ldx_load_aligner_tb_top;
  // vector: word(32) ofs(2) size(2) zext(1) exp_data(32) exp_err(1)
  localparam int NV = 18;
  localparam logic [69:0] VEC [NV] = '{
    {32'h8C0A7F55, 2'd0, 2'b00, 1'b0, 32'hFFFFFF8C, 1'b0}, // R1 R3
    {32'h8C0A7F55, 2'd0, 2'b00, 1'b1, 32'h0000008C, 1'b0}, // R4
    {32'h8C0A7F55, 2'd1, 2'b00, 1'b0, 32'h0000000A, 1'b0}, // R1 R3
    {32'h8C0A7F55, 2'd3, 2'b00, 1'b0, 32'h00000055, 1'b0}, // R1
    {32'h8C0A7F55, 2'd2, 2'b00, 1'b1, 32'h0000007F, 1'b0}, // R1 R4
    {32'h8C0A7F55, 2'd0, 2'b01, 1'b0, 32'hFFFF8C0A, 1'b0}, // R2 R3
    {32'h8C0A7F55, 2'd0, 2'b01, 1'b1, 32'h00008C0A, 1'b0}, // R2 R4
    {32'h8C0A7F55, 2'd2, 2'b01, 1'b0, 32'h00007F55, 1'b0}, // R2
    {32'h8C0A7F55, 2'd1, 2'b01, 1'b0, 32'h00000000, 1'b1}, // R6 R7
    {32'h8C0A7F55, 2'd0, 2'b10, 1'b0, 32'h8C0A7F55, 1'b0}, // R5
    {32'h8C0A7F55, 2'd0, 2'b10, 1'b1, 32'h8C0A7F55, 1'b0}, // R5
    {32'h8C0A7F55, 2'd2, 2'b10, 1'b0, 32'h00000000, 1'b1}, // R6 R7
    {32'h8C0A7F55, 2'd3, 2'b01, 1'b1, 32'h00000000, 1'b1}, // R6 R7
    {32'h12F4A0C3, 2'd2, 2'b01, 1'b0, 32'hFFFFA0C3, 1'b0}, // R2 R3
    {32'h12F4A0C3, 2'd3, 2'b00, 1'b0, 32'hFFFFFFC3, 1'b0}, // R1 R3
    {32'h12F4A0C3, 2'd1, 2'b00, 1'b1, 32'h000000F4, 1'b0}, // R1 R4
    {32'h12F4A0C3, 2'd1, 2'b10, 1'b1, 32'h00000000, 1'b1}, // R6 R7
    {32'h12F4A0C3, 2'd0, 2'b11, 1'b0, 32'h12F4A0C3, 1'b0}  // R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0;
  logic [31:0] ld_word = '0;
  logic [1:0] ld_addr_lo = '0;
  logic [1:0] ld_size = '0;
  logic ld_zext = 1'b0;
  logic res_valid, res_misalign;
  logic [31:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] last_good = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ldx_load_aligner dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_word(ld_word),
    .ld_addr_lo(ld_addr_lo), .ld_size(ld_size), .ld_zext(ld_zext),
    .res_valid(res_valid), .res_data(res_data), .res_misalign(res_misalign)
  );

  task automatic check(string req, logic [33:0] act, logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got vld/err/data=%h expected %h", req, act, exp);
    end
  endtask

  // present one strobe at a negedge, look at the result one clock later
  task automatic strobe(logic [31:0] w, logic [1:0] a, logic [1:0] s, logic z);
    ld_valid = 1'b1; ld_word = w; ld_addr_lo = a; ld_size = s; ld_zext = z;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {res_valid, res_misalign, res_data}, 34'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle", {res_valid, res_misalign, res_data}, 34'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_d;
      strobe(VEC[i][69:38], VEC[i][37:36], VEC[i][35:34], VEC[i][33]);
      exp_d = VEC[i][0] ? last_good : VEC[i][32:1];
      check($sformatf("R1-7 vector %0d", i), {res_valid, res_misalign, res_data},
            {1'b1, VEC[i][0], exp_d});
      last_good = exp_d;
    end

    // R8: strobe dropped -> valid and error drop next cycle, data kept
    ld_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 drop", {res_valid, res_misalign, res_data}, {2'b00, last_good});

    // R7 then recovery: error, then a good load clears it
    strobe(32'hA5A5A5A5, 2'd1, 2'b10, 1'b0);
    check("R7 err", {res_valid, res_misalign, res_data}, {2'b11, last_good});
    strobe(32'hA5A5A5A5, 2'd1, 2'b00, 1'b0);
    check("R3 after err", {res_valid, res_misalign, res_data}, {2'b10, 32'hFFFFFFA5});
    // R5: word with zext=1 still the whole word; negative halfword zero fill R4
    strobe(32'hF00DBEEF, 2'd0, 2'b10, 1'b1);
    check("R5 word", {res_valid, res_misalign, res_data}, {2'b10, 32'hF00DBEEF});
    strobe(32'hF00DBEEF, 2'd2, 2'b01, 1'b1);
    check("R4 half", {res_valid, res_misalign, res_data}, {2'b10, 32'h0000BEEF});

    // R9: reset mid-run while an error is showing
    strobe(32'h0, 2'd3, 2'b01, 1'b0);
    check("R7 pre-reset", {res_valid, res_misalign, res_data}, {2'b11, 32'h0000BEEF});
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 mid reset", {res_valid, res_misalign, res_data}, 34'h0);
    rst = 1'b0; ld_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule